// File: doc/BRIEF.md
# Vector prefix mode decoder

This block decodes the five-bit mode field of a vector instruction prefix. It sorts the operation into one of six classes: simple, scalar reduce, saturating, fail-first, vector-immediate or reserved. For each class it drives the matching qualifier flags. Flags that do not belong to the selected class are held at zero.

In vector-immediate mode, the instruction is followed by an inline table of extra 16-bit immediates. The decoder then acts like an unconditional branch over that table. The next address is the current address, plus 8 bytes for the prefixed instruction, plus the table size. The table holds one immediate fewer than the maximum vector length, and its size is rounded up to a whole 4-byte word. The element-width settings are never consulted. Every other class continues at the plain sequential address.

The field is declared `[0:4]` with big-endian bit numbering, so field bit 0 is the leftmost bit. Decode is combinational. The result is registered: it appears one cycle after a request marked by `in_valid` and holds until the next request. Fetching and using the immediates is left to other logic.

Top module: `vpfx_mode_dec`

## Requirements
- R1: While `rst_n` is low and after its release, before any request, `out_valid` and every output flag are 0, `mode_o` is 0 and `nia` is 0.
- R2: A request with `in_valid`=1 at a rising edge shows its results on the outputs after that edge, with `out_valid`=1. With `in_valid`=0, `out_valid` drops to 0 and all other outputs keep their values whatever the inputs do.
- R3: Field bits 0,1 = 00 and bit 2 = 0 give the simple class (`mode_o`=0). `dz` copies bit 3 and `sz` copies bit 4.
- R4: Field bits 0,1 = 00, bit 2 = 1 and bit 4 = 0 give the scalar reduce class (`mode_o`=1), with `red_var` copying bit 3.
- R5: Field bits 0,1 = 00, bit 2 = 1 and bits 3,4 = 01 give the vector-immediate class (`mode_o`=4, `vimm`=1). Bits 0,1 = 00 with bits 2,3,4 = 111 give the reserved class (`mode_o`=5, `illegal`=1). `vimm` and `illegal` are never set together.
- R6: Field bits 0,1 = 10 give the saturating class (`mode_o`=2). `sat_sgn` copies bit 2, `dz` copies bit 3 and `sz` copies bit 4.
- R7: Field bit 1 = 1 gives the fail-first class (`mode_o`=3), with `ff_vli` copying bit 0 and `ff_inv` copying bit 2. When `rc`=1, `ff_crsel` equals {bit 3, bit 4}, with bit 3 as the MSB.
- R8: In the fail-first class with `rc`=0, `ff_zz` copies bit 3, `ff_rc1` copies bit 4, and `ff_crsel` is 0.
- R9: Every class other than vector-immediate, reserved included, sets `nia` = `cia` + 8, modulo 2^ADDR_W.
- R10: The vector-immediate class sets `nia` = `cia` + 8 + 4*ceil((`maxvl`-1)/2), modulo 2^ADDR_W. A `maxvl` of 0 or 1 adds nothing beyond the 8.
- R11: Any flag output that does not belong to the decoded class is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mode_f | input | 5 | Prefix mode field, declared [0:4] |
| rc | input | 1 | Record bit of the instruction |
| cia | input | ADDR_W | Current instruction address |
| maxvl | input | MAXVL_W | Maximum vector length |
| out_valid | output | 1 | Result registered this cycle |
| mode_o | output | 3 | Class: 0 simple, 1 reduce, 2 saturate, 3 fail-first, 4 vector-immediate, 5 reserved |
| illegal | output | 1 | Reserved encoding |
| vimm | output | 1 | Vector-immediate skip taken |
| dz | output | 1 | Destination zeroing |
| sz | output | 1 | Source zeroing |
| red_var | output | 1 | Reduce variant |
| sat_sgn | output | 1 | Signed saturation |
| ff_vli | output | 1 | Fail-first length-inclusive |
| ff_inv | output | 1 | Fail-first invert test |
| ff_crsel | output | 2 | Fail-first condition bit select (rc=1) |
| ff_zz | output | 1 | Fail-first zero test (rc=0) |
| ff_rc1 | output | 1 | Fail-first Rc1 behaviour (rc=0) |
| nia | output | ADDR_W | Next instruction address |

## Verification
Only 1 of the 32 field encodings selects the vector-immediate skip. The hardest cases to reach are that encoding combined with a `maxvl` at its extremes (0, 1, 2, odd values and all-ones) and with a `cia` close enough to the top of the address space that the sum wraps. The bench drives that encoding directly at each extreme length and at a wrapping address. It also sweeps all 32 field values under both `rc` settings, then mixes in random requests in which the vector-immediate encoding is forced often.

// File: rtl/vpfx_mode_dec.sv
module vpfx_mode_dec #(
  parameter int ADDR_W  = 64,
  parameter int MAXVL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [0:4]        mode_f,
  input  logic              rc,
  input  logic [ADDR_W-1:0] cia,
  input  logic [MAXVL_W-1:0] maxvl,
  output logic              out_valid,
  output logic [2:0]        mode_o,
  output logic              illegal,
  output logic              vimm,
  output logic              dz,
  output logic              sz,
  output logic              red_var,
  output logic              sat_sgn,
  output logic              ff_vli,
  output logic              ff_inv,
  output logic [1:0]        ff_crsel,
  output logic              ff_zz,
  output logic              ff_rc1,
  output logic [ADDR_W-1:0] nia
);
  localparam logic [2:0] K_SIMPLE = 3'd0;
  localparam logic [2:0] K_RED    = 3'd1;
  localparam logic [2:0] K_SAT    = 3'd2;
  localparam logic [2:0] K_FF     = 3'd3;
  localparam logic [2:0] K_VIMM   = 3'd4;
  localparam logic [2:0] K_RSV    = 3'd5;
  localparam int         WRD_W    = MAXVL_W + 1;

  wire b0 = mode_f[0];
  wire b1 = mode_f[1];
  wire b2 = mode_f[2];
  wire b3 = mode_f[3];
  wire b4 = mode_f[4];

  wire is_ff  = b1;
  wire is_sat = b0 & ~b1;
  wire is_m00 = ~b0 & ~b1;
  wire is_smp = is_m00 & ~b2;
  wire is_red = is_m00 & b2 & ~b4;
  wire is_vi  = is_m00 & b2 & ~b3 & b4;
  wire is_rsv = is_m00 & b2 & b3 & b4;

  logic [MAXVL_W-1:0] extra_n;
  logic [WRD_W-1:0]   words_n;
  logic [ADDR_W-1:0]  skip_b;
  logic [ADDR_W-1:0]  nia_c;
  logic [2:0]         kind_c;

  assign extra_n = (maxvl > MAXVL_W'(1)) ? maxvl - MAXVL_W'(1) : '0;
  assign words_n = ({1'b0, extra_n} + WRD_W'(1)) >> 1;
  assign skip_b  = is_vi ? ADDR_W'({words_n, 2'b00}) : '0;
  assign nia_c   = cia + ADDR_W'(8) + skip_b;

  always_comb begin
    kind_c = K_SIMPLE;
    if (is_ff)       kind_c = K_FF;
    else if (is_sat) kind_c = K_SAT;
    else if (is_red) kind_c = K_RED;
    else if (is_vi)  kind_c = K_VIMM;
    else if (is_rsv) kind_c = K_RSV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mode_o    <= '0;
      illegal   <= 1'b0;
      vimm      <= 1'b0;
      dz        <= 1'b0;
      sz        <= 1'b0;
      red_var   <= 1'b0;
      sat_sgn   <= 1'b0;
      ff_vli    <= 1'b0;
      ff_inv    <= 1'b0;
      ff_crsel  <= '0;
      ff_zz     <= 1'b0;
      ff_rc1    <= 1'b0;
      nia       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        mode_o   <= kind_c;
        illegal  <= is_rsv;
        vimm     <= is_vi;
        dz       <= (is_smp | is_sat) & b3;
        sz       <= (is_smp | is_sat) & b4;
        red_var  <= is_red & b3;
        sat_sgn  <= is_sat & b2;
        ff_vli   <= is_ff & b0;
        ff_inv   <= is_ff & b2;
        ff_crsel <= (is_ff & rc) ? {b3, b4} : 2'b00;
        ff_zz    <= is_ff & ~rc & b3;
        ff_rc1   <= is_ff & ~rc & b4;
        nia      <= nia_c;
      end
    end
  end

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(vimm && illegal));

  p_vimm_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vimm |-> (mode_o == K_VIMM));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(nia) && $stable(mode_o) && !out_valid));

  p_ff_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_f[1]) |=> (nia == $past(cia) + ADDR_W'(8) && !vimm));

  p_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (nia[1:0] == $past(cia[1:0])));

  p_ffonly_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_o != K_FF) |-> (!ff_vli && !ff_inv && ff_crsel == 2'b00 && !ff_zz && !ff_rc1));

  p_rc_split_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ff_crsel != 2'b00 && (ff_zz || ff_rc1)));
endmodule

// File: tb/vpfx_mode_dec_tb.sv
module vpfx_mode_dec_tb;
  localparam int AW = 64;
  localparam int VW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [0:4] mode_f = '0;
  logic rc = 1'b0;
  logic [AW-1:0] cia = '0;
  logic [VW-1:0] maxvl = '0;
  logic out_valid, illegal, vimm, dz, sz, red_var, sat_sgn, ff_vli, ff_inv, ff_zz, ff_rc1;
  logic [2:0] mode_o;
  logic [1:0] ff_crsel;
  logic [AW-1:0] nia;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  vpfx_mode_dec #(.ADDR_W(AW), .MAXVL_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_f(mode_f), .rc(rc),
    .cia(cia), .maxvl(maxvl), .out_valid(out_valid), .mode_o(mode_o),
    .illegal(illegal), .vimm(vimm), .dz(dz), .sz(sz), .red_var(red_var),
    .sat_sgn(sat_sgn), .ff_vli(ff_vli), .ff_inv(ff_inv), .ff_crsel(ff_crsel),
    .ff_zz(ff_zz), .ff_rc1(ff_rc1), .nia(nia)
  );

  // {mode3, illegal, vimm, dz, sz, red_var, sat_sgn, ff_vli, ff_inv, crsel2, zz, rc1}
  function automatic logic [14:0] exp_flags(input logic [0:4] m, input logic r);
    logic [2:0] k;
    logic il, vi, d, s, rv, sg, vl, iv, zz, r1;
    logic [1:0] cs;
    {il, vi, d, s, rv, sg, vl, iv, zz, r1} = '0;
    cs = 2'b00;
    if (m[1] == 1'b1) begin
      k = 3'd3; vl = m[0]; iv = m[2];
      if (r) cs = {m[3], m[4]};
      else begin zz = m[3]; r1 = m[4]; end
    end else if (m[0] == 1'b1) begin
      k = 3'd2; sg = m[2]; d = m[3]; s = m[4];
    end else if (m[2] == 1'b0) begin
      k = 3'd0; d = m[3]; s = m[4];
    end else if (m[4] == 1'b0) begin
      k = 3'd1; rv = m[3];
    end else if (m[3] == 1'b0) begin
      k = 3'd4; vi = 1'b1;
    end else begin
      k = 3'd5; il = 1'b1;
    end
    return {k, il, vi, d, s, rv, sg, vl, iv, cs, zz, r1};
  endfunction

  function automatic logic [AW-1:0] exp_nia(input logic [0:4] m, input logic [AW-1:0] a,
                                            input logic [VW-1:0] mv);
    logic [AW-1:0] extra;
    extra = '0;
    if (m == 5'b00101 && mv > 1) extra = AW'(((int'(mv) - 1) * 2 + 3) / 4 * 4);
    return a + 64'd8 + extra;
  endfunction

  function automatic string req_of(input logic [2:0] k, input logic r);
    case (k)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R6";
      3'd3: return r ? "R7" : "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic logic [14:0] got_flags();
    return {mode_o, illegal, vimm, dz, sz, red_var, sat_sgn, ff_vli, ff_inv, ff_crsel, ff_zz, ff_rc1};
  endfunction

  task automatic issue(input logic [0:4] m, input logic r, input logic [AW-1:0] a,
                       input logic [VW-1:0] mv);
    logic [14:0] ef;
    @(negedge clk);
    mode_f = m; rc = r; cia = a; maxvl = mv; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ef = exp_flags(m, r);
    chk("R2", AW'(out_valid), 64'd1);
    chk(req_of(ef[14:12], r), AW'(got_flags()), AW'(ef));
    chk((m == 5'b00101) ? "R10" : "R9", nia, exp_nia(m, a, mv));
    chk("R11", AW'(got_flags() & ~ef), 64'd0);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [14:0] held;
    logic [AW-1:0] held_nia;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", AW'(got_flags()), 64'd0);
    chk("R1", nia, 64'd0);
    chk("R1", AW'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", AW'(got_flags()), 64'd0);

    for (int r = 0; r < 2; r++)
      for (int m = 0; m < 32; m++)
        issue(5'(m), 1'(r), 64'h0000_1000_0000_0100 + AW'(m * 16), 7'd5);

    issue(5'b00111, 1'b0, 64'h40, 7'd9);
    chk("R5", AW'(illegal), 64'd1);

    for (int mv = 0; mv < 8; mv++) issue(5'b00101, 1'b0, 64'h2000, 7'(mv));
    issue(5'b00101, 1'b1, 64'h2000, 7'd64);
    issue(5'b00101, 1'b0, 64'h2000, 7'd127);
    issue(5'b00101, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 7'd40);
    issue(5'b00111, 1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 7'd40);

    issue(5'b10011, 1'b0, 64'h3000, 7'd3);
    held = got_flags(); held_nia = nia;
    @(negedge clk);
    mode_f = 5'b00101; rc = 1'b1; cia = 64'hABCD; maxvl = 7'd100;
    @(negedge clk);
    chk("R2", AW'(out_valid), 64'd0);
    chk("R2", AW'(got_flags()), AW'(held));
    chk("R2", nia, held_nia);

    for (int i = 0; i < 3000; i++) begin
      logic [0:4] m;
      m = 5'($urandom);
      if (($urandom % 4) == 0) m = 5'b00101;
      issue(m, 1'($urandom), {$urandom, $urandom}, 7'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule